// File: doc/BRIEF.md
# Three-Channel Interval Timer with PWM Outputs

The block holds three identical timer channels behind one 32-bit register bus. Each channel has a counter that can count up or down. In interval mode the count is bounded by a programmable interval value, and the channel turns that count into a pulse-width-modulated output whose level changes where the count crosses a programmable match value. The rate at which a channel counts is the input clock, or the input clock divided by a power of two that software selects.

Software sets up a channel in a fixed order. It stops the counter, writes the divider, the interval and the match values, and then writes the channel's control word with the restart bit set. The restart loads the start count and realigns the divider, so the first period begins cleanly. Each channel's counter, configuration and output are independent of the other two. A channel can be frozen or have its output silenced without losing its count.

Top module: `tri_timer_pwm`

## Requirements
- R1: After reset every register reads 0 except the control word, which reads 0x1 (counting stopped). All pwm_out bits are 0 and all counts are 0.
- R2: Word offsets are: divider setup 0x00+4c, control word 0x0C+4c, current count 0x18+4c (read only; writes are ignored), interval 0x24+4c and match 0x30+4c, where c is 0 to 2. A read returns its data on bus_rdata in the cycle after bus_rd. Reads at any other offset return 0.
- R3: The interval and match registers keep only the low CW bits of a write, so a write of 0xFFFF1234 reads back as 0x1234 with CW=16.
- R4: The divider setup word has bit 0 for divide enable and bits 4:1 for the value N. With divide enabled, the count steps once every 2^(N+1) clocks. With it disabled, the count steps every clock.
- R5: Control word bits: 0 stop, 1 interval mode, 2 count down, 3 match enable, 4 restart, 5 output off, 6 invert. When counting up in interval mode, a step from a count equal to or above the interval goes to 0; otherwise the count goes up by 1.
- R6: When counting down in interval mode, a step from 0 reloads the interval value; otherwise the count goes down by 1.
- R7: Outside interval mode the count wraps freely: up from 2^CW-1 to 0, and down from 0 to 2^CW-1.
- R8: While the stop bit is 1, the count and the divider phase hold their values.
- R9: A control write with the restart bit set loads the count on that clock edge. The count becomes 0 when the written count-down bit is 0, and the interval value when it is 1. The write also clears the divider phase. The restart bit always reads back as 0.
- R10: One clock after a count value, pwm_out takes the value ((match enable AND count < match) XOR invert).
- R11: While the output-off bit is 1, that channel's pwm_out is 0 one clock later, whatever the invert bit is.
- R12: A write to one channel's registers changes no other channel's registers, count or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | AW | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| pwm_out | output | 3 | Waveform output of each channel |

## Verification
A write takes effect on the clock edge that samples it: a restart loads the count on that edge, and new settings govern the very next step. Read data is due one cycle after the strobe, and the bench samples it at the following falling edge. Each output bit is due one cycle after the count it is derived from. The bench model applies this one-cycle lag to its own count and compares all three outputs at every falling edge, so a step that is early or late by a single clock, or a wrong divider phase, shows up at once.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
  localparam int NCH = 3;
  localparam int PW  = 4;
  localparam logic [7:0] OFS_DIV = 8'h00;
  localparam logic [7:0] OFS_CTL = 8'h0C;
  localparam logic [7:0] OFS_CNT = 8'h18;
  localparam logic [7:0] OFS_INT = 8'h24;
  localparam logic [7:0] OFS_MAT = 8'h30;

  typedef struct packed {
    logic [PW-1:0] val;
    logic          en;
  } div_cfg_t;

  typedef struct packed {
    logic invert;
    logic out_off;
    logic match_en;
    logic down;
    logic interval;
    logic stop;
  } ctl_cfg_t;
endpackage

// File: rtl/tpwm_divider.sv
module tpwm_divider #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          clr,
  input  logic          en,
  input  logic [PW-1:0] val,
  output logic          tick
);
  localparam int DW = 2 ** PW;

  logic [DW-1:0] phase;
  logic [DW-1:0] limit;

  always_comb begin
    limit = {DW{1'b1}} >> (DW - 1 - int'(val));
    tick  = run && (!en || phase == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) phase <= '0;
    else if (run) begin
      if (tick) phase <= '0;
      else      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/tpwm_counter.sv
module tpwm_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          load_down,
  input  logic          tick,
  input  logic          interval,
  input  logic          down,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] nxt;

  always_comb begin
    if (down) nxt = (interval && cnt == '0) ? limit : cnt - 1'b1;
    else      nxt = (interval && cnt >= limit) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_down ? limit : '0;
    else if (tick) cnt <= nxt;
  end
endmodule

// File: rtl/tpwm_wave.sv
module tpwm_wave #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] match,
  input  logic          match_en,
  input  logic          invert,
  input  logic          out_off,
  output logic          wave
);
  always_ff @(posedge clk) begin
    if (rst || out_off) wave <= 1'b0;
    else                wave <= (match_en && cnt < match) ^ invert;
  end
endmodule

// File: rtl/tpwm_channel.sv
module tpwm_channel
  import tpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_div,
  input  logic          wr_ctl,
  input  logic          wr_int,
  input  logic          wr_mat,
  input  logic [31:0]   wdata,
  output div_cfg_t      div_q,
  output ctl_cfg_t      ctl_q,
  output logic [CW-1:0] int_q,
  output logic [CW-1:0] mat_q,
  output logic [CW-1:0] cnt,
  output logic          tick,
  output logic          restart,
  output logic          wave
);
  assign restart = wr_ctl && wdata[4];

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      ctl_q <= '{stop: 1'b1, default: 1'b0};
      int_q <= '0;
      mat_q <= '0;
    end else begin
      if (wr_div) div_q <= '{val: wdata[PW:1], en: wdata[0]};
      if (wr_ctl) ctl_q <= '{invert: wdata[6], out_off: wdata[5], match_en: wdata[3],
                             down: wdata[2], interval: wdata[1], stop: wdata[0]};
      if (wr_int) int_q <= wdata[CW-1:0];
      if (wr_mat) mat_q <= wdata[CW-1:0];
    end
  end

  tpwm_divider #(.PW(PW)) u_div (
    .clk(clk), .rst(rst), .run(!ctl_q.stop), .clr(restart),
    .en(div_q.en), .val(div_q.val), .tick(tick)
  );

  tpwm_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(restart), .load_down(wdata[2]), .tick(tick),
    .interval(ctl_q.interval), .down(ctl_q.down), .limit(int_q), .cnt(cnt)
  );

  tpwm_wave #(.CW(CW)) u_wave (
    .clk(clk), .rst(rst), .cnt(cnt), .match(mat_q), .match_en(ctl_q.match_en),
    .invert(ctl_q.invert), .out_off(ctl_q.out_off), .wave(wave)
  );
endmodule

// File: rtl/tri_timer_pwm.sv
module tri_timer_pwm
  import tpwm_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_rd,
  output logic [31:0]   bus_rdata,
  output logic [2:0]    pwm_out
);
  div_cfg_t [NCH-1:0]         div_all;
  ctl_cfg_t [NCH-1:0]         ctl_all;
  logic [NCH-1:0][CW-1:0]     int_all;
  logic [NCH-1:0][CW-1:0]     mat_all;
  logic [NCH-1:0][CW-1:0]     cnt_all;
  logic [NCH-1:0]             tick_all;
  logic [NCH-1:0]             restart_all;
  logic [NCH-1:0]             wave_all;
  logic [AW-1:0]              word_addr;

  assign word_addr = {bus_addr[AW-1:2], 2'b00};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] STEP = AW'(4 * c);
    tpwm_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst),
      .wr_div(bus_wr && word_addr == AW'(OFS_DIV) + STEP),
      .wr_ctl(bus_wr && word_addr == AW'(OFS_CTL) + STEP),
      .wr_int(bus_wr && word_addr == AW'(OFS_INT) + STEP),
      .wr_mat(bus_wr && word_addr == AW'(OFS_MAT) + STEP),
      .wdata(bus_wdata),
      .div_q(div_all[c]), .ctl_q(ctl_all[c]), .int_q(int_all[c]), .mat_q(mat_all[c]),
      .cnt(cnt_all[c]), .tick(tick_all[c]), .restart(restart_all[c]), .wave(wave_all[c])
    );
  end

  assign pwm_out = wave_all;

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCH; c++) begin
      if (word_addr == AW'(OFS_DIV) + AW'(4 * c))
        rd_mux = {27'b0, div_all[c].val, div_all[c].en};
      if (word_addr == AW'(OFS_CTL) + AW'(4 * c))
        rd_mux = {25'b0, ctl_all[c].invert, ctl_all[c].out_off, 1'b0, ctl_all[c].match_en,
                  ctl_all[c].down, ctl_all[c].interval, ctl_all[c].stop};
      if (word_addr == AW'(OFS_CNT) + AW'(4 * c)) rd_mux = 32'(cnt_all[c]);
      if (word_addr == AW'(OFS_INT) + AW'(4 * c)) rd_mux = 32'(int_all[c]);
      if (word_addr == AW'(OFS_MAT) + AW'(4 * c)) rd_mux = 32'(mat_all[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/tpwm_checker.sv
module tpwm_checker #(
  parameter int CW = 16,
  parameter int AW = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [AW-1:0]      bus_addr,
  input logic               bus_rd,
  input logic [31:0]        bus_rdata,
  input logic [2:0]         pwm_out,
  input logic [2:0][CW-1:0] cnt_all,
  input logic [2:0][CW-1:0] int_all,
  input logic [2:0]         tick_all,
  input logic [2:0]         restart_all,
  input logic [2:0]         stop_all,
  input logic [2:0]         down_all,
  input logic [2:0]         ival_all,
  input logic [2:0]         off_all
);
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd) && $past(bus_addr) >= AW'(8'h3C) |-> bus_rdata == 32'h0);

  for (genvar c = 0; c < 3; c++) begin : g_chk
    a_r8_stop_holds: assert property (@(posedge clk) disable iff (rst)
      $past(stop_all[c]) && !$past(restart_all[c]) |-> cnt_all[c] == $past(cnt_all[c]));

    a_r5_up_step: assert property (@(posedge clk) disable iff (rst)
      $past(tick_all[c]) && $past(ival_all[c]) && !$past(down_all[c]) && !$past(restart_all[c])
      |-> cnt_all[c] == CW'($past(cnt_all[c]) + 1'b1) || cnt_all[c] == '0);

    a_r6_down_step: assert property (@(posedge clk) disable iff (rst)
      $past(tick_all[c]) && $past(ival_all[c]) && $past(down_all[c]) && !$past(restart_all[c])
      |-> cnt_all[c] == CW'($past(cnt_all[c]) - 1'b1) || cnt_all[c] == $past(int_all[c]));

    a_r9_restart_load: assert property (@(posedge clk) disable iff (rst)
      $past(restart_all[c]) |-> cnt_all[c] == '0 || cnt_all[c] == $past(int_all[c]));

    a_r11_output_off: assert property (@(posedge clk) disable iff (rst)
      $past(off_all[c]) |-> !pwm_out[c]);
  end
endmodule

bind tri_timer_pwm tpwm_checker #(.CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pwm_out(pwm_out), .cnt_all(cnt_all), .int_all(int_all), .tick_all(tick_all),
  .restart_all(restart_all),
  .stop_all({ctl_all[2].stop, ctl_all[1].stop, ctl_all[0].stop}),
  .down_all({ctl_all[2].down, ctl_all[1].down, ctl_all[0].down}),
  .ival_all({ctl_all[2].interval, ctl_all[1].interval, ctl_all[0].interval}),
  .off_all({ctl_all[2].out_off, ctl_all[1].out_off, ctl_all[0].out_off})
);

// File: tb/sim_tri_timer_pwm.sv
module sim_tri_timer_pwm;
  localparam int CW = 16;
  localparam int MAXC = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [2:0]  pwm_out;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  tri_timer_pwm #(.CW(CW), .AW(8)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  int m_pe[3], m_pv[3], m_stop[3], m_iv[3], m_dn[3], m_me[3], m_off[3], m_inv[3];
  int m_int[3], m_mat[3], m_cnt[3], m_ph[3];
  int exp_pwm[3];
  int exp_rd;

  function automatic int model_read(int a);
    int w;
    w = a & 32'hFC;
    for (int c = 0; c < 3; c++) begin
      if (w == 8'h00 + 4 * c) return m_pe[c] | (m_pv[c] << 1);
      if (w == 8'h0C + 4 * c) return m_stop[c] | (m_iv[c] << 1) | (m_dn[c] << 2) |
                                     (m_me[c] << 3) | (m_off[c] << 5) | (m_inv[c] << 6);
      if (w == 8'h18 + 4 * c) return m_cnt[c];
      if (w == 8'h24 + 4 * c) return m_int[c];
      if (w == 8'h30 + 4 * c) return m_mat[c];
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 3; c++) begin
        m_pe[c] = 0; m_pv[c] = 0; m_stop[c] = 1; m_iv[c] = 0; m_dn[c] = 0; m_me[c] = 0;
        m_off[c] = 0; m_inv[c] = 0; m_int[c] = 0; m_mat[c] = 0; m_cnt[c] = 0; m_ph[c] = 0;
        exp_pwm[c] = 0;
      end
      exp_rd = 0;
    end else begin
      int w;
      w = bus_addr & 32'hFC;
      if (bus_rd) exp_rd = model_read(bus_addr);
      for (int c = 0; c < 3; c++) begin
        bit tick, restart;
        exp_pwm[c] = m_off[c] ? 0 : (((m_me[c] != 0) && (m_cnt[c] < m_mat[c])) ? 1 : 0) ^ m_inv[c];
        tick = (m_stop[c] == 0) && (m_pe[c] == 0 || m_ph[c] == (1 << (m_pv[c] + 1)) - 1);
        restart = bus_wr && w == 8'h0C + 4 * c && bus_wdata[4];
        if (restart) begin
          m_cnt[c] = bus_wdata[2] ? m_int[c] : 0;
          m_ph[c] = 0;
        end else if (m_stop[c] == 0) begin
          if (tick) begin
            m_ph[c] = 0;
            if (m_dn[c] != 0) m_cnt[c] = (m_iv[c] != 0 && m_cnt[c] == 0) ? m_int[c] : (m_cnt[c] - 1) & MAXC;
            else m_cnt[c] = (m_iv[c] != 0 && m_cnt[c] >= m_int[c]) ? 0 : (m_cnt[c] + 1) & MAXC;
          end else m_ph[c] = m_ph[c] + 1;
        end
        if (bus_wr) begin
          if (w == 8'h00 + 4 * c) begin m_pe[c] = bus_wdata[0]; m_pv[c] = int'(bus_wdata[4:1]); end
          if (w == 8'h0C + 4 * c) begin
            m_stop[c] = bus_wdata[0]; m_iv[c] = bus_wdata[1]; m_dn[c] = bus_wdata[2];
            m_me[c] = bus_wdata[3]; m_off[c] = bus_wdata[5]; m_inv[c] = bus_wdata[6];
          end
          if (w == 8'h24 + 4 * c) m_int[c] = bus_wdata & MAXC;
          if (w == 8'h30 + 4 * c) m_mat[c] = bus_wdata & MAXC;
        end
      end
    end
  end

  // R10 R11 R4 R5 R6 R7 R8 R9 R12: outputs against the model every cycle
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      for (int c = 0; c < 3; c++) begin
        checks++;
        if (int'(pwm_out[c]) != exp_pwm[c]) begin
          fails++;
          $display("FAIL R10 ch%0d pwm at cycle %0d: actual %0d expected %0d", c, cycles, pwm_out[c], exp_pwm[c]);
        end
      end
    end
  end

  task automatic wr(input int a, input int d);
    bus_addr = 8'(a); bus_wdata = 32'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_fixed(input int a, input int expv, input string tag);
    bus_addr = 8'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    checks++;
    if (bus_rdata != 32'(expv)) begin
      fails++;
      $display("FAIL %s read 0x%02h: actual 0x%08h expected 0x%08h", tag, a, bus_rdata, expv);
    end
  endtask

  task automatic rd_model(input int a, input string tag);
    bus_addr = 8'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    checks++;
    if (bus_rdata != 32'(exp_rd)) begin
      fails++;
      $display("FAIL %s read 0x%02h: actual 0x%08h expected 0x%08h", tag, a, bus_rdata, exp_rd);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int c = 0; c < 3; c++) begin
      rd_fixed(8'h0C + 4 * c, 1, "R1");
      rd_fixed(8'h00 + 4 * c, 0, "R1");
      rd_fixed(8'h18 + 4 * c, 0, "R1");
      rd_fixed(8'h24 + 4 * c, 0, "R1");
    end
    checks++;
    if (pwm_out != 3'b000) begin
      fails++;
      $display("FAIL R1 pwm after reset: actual %b expected 000", pwm_out);
    end
    // R2 unmapped offsets and ignored count write
    rd_fixed(8'h3C, 0, "R2");
    rd_fixed(8'hF0, 0, "R2");
    wr(8'h18, 32'h55);
    rd_fixed(8'h18, 0, "R2");
    // R3 masking
    wr(8'h24, 32'hFFFF1234);
    rd_fixed(8'h24, 32'h1234, "R3");
    wr(8'h30, 32'hABCD0007);
    rd_fixed(8'h30, 32'h0007, "R3");

    // ch0: up, interval 9, match 4, undivided
    wr(8'h24, 9);
    wr(8'h30, 4);
    wr(8'h0C, 32'h1A);
    rd_fixed(8'h0C, 32'h0A, "R9");
    idle(30);
    rd_model(8'h18, "R5");
    // R12 other channels untouched
    rd_fixed(8'h28, 0, "R12");
    rd_fixed(8'h10, 1, "R12");

    // ch1: down, interval 5, match 3, divide by 4, inverted
    wr(8'h04, 32'h3);
    wr(8'h28, 5);
    wr(8'h34, 3);
    wr(8'h10, 32'h5E);
    idle(50);
    rd_model(8'h1C, "R6");
    rd_model(8'h04, "R4");
    // divide by 16 on ch1
    wr(8'h04, 32'h7);
    wr(8'h10, 32'h5E);
    idle(120);
    rd_model(8'h1C, "R4");

    // ch2: free-running down through zero, then up
    wr(8'h2C, 3);
    wr(8'h38, 32'h8000);
    wr(8'h14, 32'h1C);
    idle(8);
    rd_model(8'h20, "R7");
    wr(8'h14, 32'h18);
    idle(12);
    rd_model(8'h20, "R7");

    // R8 stop holds count
    wr(8'h0C, 32'h0B);
    rd_model(8'h18, "R8");
    idle(15);
    rd_model(8'h18, "R8");
    wr(8'h0C, 32'h0A);
    idle(7);
    rd_model(8'h18, "R8");

    // R11 output off on inverted channel
    wr(8'h10, 32'h6E);
    idle(20);
    checks++;
    if (pwm_out[1] !== 1'b0) begin
      fails++;
      $display("FAIL R11 ch1 output off: actual %b expected 0", pwm_out[1]);
    end
    wr(8'h10, 32'h4E);
    idle(20);

    // R9 restart mid-period, up then down
    wr(8'h0C, 32'h1A);
    rd_model(8'h18, "R9");
    wr(8'h0C, 32'h1E);
    rd_model(8'h18, "R9");
    idle(25);
    rd_model(8'h18, "R6");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule